// File: doc/BRIEF.md
# Opcode Decoder for a Small 8-bit Processor

This block turns one opcode byte into the control fields an execution unit needs. The upper nibble picks one of sixteen base operations. For some of them the lower nibble then picks an operand form or a branch condition. For the others the lower nibble must be zero. The decoder is purely combinational: the fetch stage presents the opcode byte and reads back, in the same cycle, the following fields:
- the instruction class;
- the operand addressing form;
- the ALU function;
- the branch condition;
- how many operand bytes follow the opcode;
- whether the opcode is illegal.

Operands name registers through register-specifier bytes. Each such byte packs two 4-bit register indices, so a form that names n registers spends ceil(n/2) bytes on them. Immediate data and addresses follow those bytes. An illegal opcode is reported on its own flag, and every other output then reads as a no-operation, so the sequencer can trap without acting on stray fields.

Top module: `opcode_decoder`

## Requirements
- R1: For every legal opcode the class output follows the upper nibble. The class codes are nop=0, move=1, load=2, store=3, arithmetic/logic=4, shift=5, compare=6, jump=7, return=8, halt=9. Upper nibbles 4..A give class 4, B gives 5, C gives 6, D gives 7, E gives 8 and F gives 9.
- R2: Upper nibbles 0, 1, B, E and F are legal only when the lower nibble is 0; any other lower nibble sets the illegal flag.
- R3: Load (upper nibble 2) maps lower nibble 0..4 to the modes immediate8(2), indexed zero page(3), immediate zero page(4), indexed absolute(5) and immediate absolute(6). Lower nibbles 5..F are illegal. The remaining mode codes are none=0 and register=1.
- R4: Store (upper nibble 3) maps lower nibble 0..3 to indexed zero page(3), immediate zero page(4), indexed absolute(5) and immediate absolute(6). Lower nibbles 4..F are illegal.
- R5: Upper nibbles 4..A and C accept lower nibble 0 (register mode 1) or 1 (immediate8 mode 2); other lower nibbles are illegal. The ALU code is 0 = pass, add=1, adc=2, sub=3, sbb=4, and=5, or=6, xor=7, shr=8, and compare selects sub (3). Only classes 4, 5 and 6 drive a nonzero ALU code.
- R6: Jump (upper nibble D) accepts every lower nibble. Condition = lower nibble bits 3..1, in the order always(0), carry, overflow, zero, negative, greater, less, input(7). Bit 0 picks indexed absolute (0, mode 5) or immediate absolute (1, mode 6). Every non-jump opcode gives condition 0.
- R7: An illegal opcode drives illegal=1 with class 0, mode 0, ALU code 0, condition 0 and operand count 0. A legal opcode drives illegal=0.
- R8: Operand count = ceil(registers named / 2) + immediate bytes. Immediate8 and immediate zero page add 1 and immediate absolute adds 2. The result is 0 for nop, return and halt, and 3 at most.
- R9: Exactly 46 of the 256 opcode values are legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Opcode byte under decode |
| iclass_o | output | 4 | Instruction class code |
| amode_o | output | 3 | Operand addressing mode code |
| alu_op_o | output | 4 | ALU function select |
| cond_o | output | 3 | Branch condition select |
| operand_bytes_o | output | 2 | Bytes that follow the opcode |
| illegal_o | output | 1 | Opcode not in the instruction set |

## Verification
Whenever the opcode changes, the checker tests how the outputs relate to each other and to the opcode. It checks that an illegal opcode forces every field to zero. It checks that conditions appear only on jumps and that ALU codes appear only on the arithmetic, shift and compare classes. It checks that the zero-low-nibble classes reject other low nibbles, and that operand counts agree with the mode. The exact mode per low nibble and the exact byte counts can only be shown by the bench. The bench compares all 256 opcodes against its own model of the instruction set, then checks that exactly 46 opcodes are legal.

// File: rtl/opdec_pkg.sv
// Package: shared widths and code types for the opcode decoder.
// Assumes an 8-bit opcode split into two equal nibbles.
package opdec_pkg;
    localparam int OPC_W = 8;
    localparam int NIB_W = OPC_W / 2;
    localparam int LEN_W = 2;
    localparam int REG_W = 2;

    typedef enum logic [3:0] {
        CL_NOP = 4'd0, CL_MOV = 4'd1, CL_LOAD = 4'd2, CL_STORE = 4'd3,
        CL_ALU = 4'd4, CL_SHIFT = 4'd5, CL_CMP = 4'd6, CL_JUMP = 4'd7,
        CL_RET = 4'd8, CL_HALT = 4'd9
    } iclass_e;

    typedef enum logic [2:0] {
        AM_NONE = 3'd0, AM_REG = 3'd1, AM_IMM8 = 3'd2, AM_ZP_IDX = 3'd3,
        AM_ZP_IMM = 3'd4, AM_ABS_IDX = 3'd5, AM_ABS_IMM = 3'd6
    } amode_e;

    typedef enum logic [3:0] {
        FN_PASS = 4'd0, FN_ADD = 4'd1, FN_ADC = 4'd2, FN_SUB = 4'd3,
        FN_SBB = 4'd4, FN_AND = 4'd5, FN_OR = 4'd6, FN_XOR = 4'd7,
        FN_SHR = 4'd8
    } alu_fn_e;
endpackage

// File: rtl/opdec_class.sv
// Module: maps the upper nibble to class and ALU function, and says
// whether that class demands a zero lower nibble. Assumes NIB_W = 4.
module opdec_class
    import opdec_pkg::*;
(
    input  logic [NIB_W-1:0] hi_i,
    output iclass_e          cls_o,
    output alu_fn_e          fn_o,
    output logic             zero_lo_o
);
    // Base operation lookup from the upper nibble.
    always_comb begin
        cls_o     = CL_NOP;
        fn_o      = FN_PASS;
        zero_lo_o = 1'b0;
        case (hi_i)
            4'h0: begin cls_o = CL_NOP;   zero_lo_o = 1'b1; end
            4'h1: begin cls_o = CL_MOV;   zero_lo_o = 1'b1; end
            4'h2: cls_o = CL_LOAD;
            4'h3: cls_o = CL_STORE;
            4'h4: begin cls_o = CL_ALU; fn_o = FN_ADD; end
            4'h5: begin cls_o = CL_ALU; fn_o = FN_ADC; end
            4'h6: begin cls_o = CL_ALU; fn_o = FN_SUB; end
            4'h7: begin cls_o = CL_ALU; fn_o = FN_SBB; end
            4'h8: begin cls_o = CL_ALU; fn_o = FN_AND; end
            4'h9: begin cls_o = CL_ALU; fn_o = FN_OR;  end
            4'hA: begin cls_o = CL_ALU; fn_o = FN_XOR; end
            4'hB: begin cls_o = CL_SHIFT; fn_o = FN_SHR; zero_lo_o = 1'b1; end
            4'hC: begin cls_o = CL_CMP; fn_o = FN_SUB; end
            4'hD: cls_o = CL_JUMP;
            4'hE: begin cls_o = CL_RET;  zero_lo_o = 1'b1; end
            default: begin cls_o = CL_HALT; zero_lo_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/opdec_variant.sv
// Module: decodes the lower nibble within a class into mode, condition,
// legality, count of named registers and immediate byte count.
// Assumes the class has already been taken from the upper nibble.
module opdec_variant
    import opdec_pkg::*;
(
    input  iclass_e          cls_i,
    input  logic [NIB_W-1:0] lo_i,
    input  logic             zero_lo_i,
    output amode_e           mode_o,
    output logic [2:0]       cond_o,
    output logic             legal_o,
    output logic [REG_W-1:0] nregs_o,
    output logic [LEN_W-1:0] immb_o
);
    // Per-class sub-decode of the lower nibble.
    always_comb begin
        mode_o  = AM_NONE;
        cond_o  = 3'd0;
        legal_o = 1'b1;
        nregs_o = '0;
        case (cls_i)
            CL_MOV, CL_SHIFT: begin mode_o = AM_REG; nregs_o = 2'd2; end
            CL_LOAD: begin
                case (lo_i)
                    4'h0: begin mode_o = AM_IMM8;    nregs_o = 2'd1; end
                    4'h1: begin mode_o = AM_ZP_IDX;  nregs_o = 2'd2; end
                    4'h2: begin mode_o = AM_ZP_IMM;  nregs_o = 2'd1; end
                    4'h3: begin mode_o = AM_ABS_IDX; nregs_o = 2'd3; end
                    4'h4: begin mode_o = AM_ABS_IMM; nregs_o = 2'd1; end
                    default: legal_o = 1'b0;
                endcase
            end
            CL_STORE: begin
                case (lo_i)
                    4'h0: begin mode_o = AM_ZP_IDX;  nregs_o = 2'd2; end
                    4'h1: begin mode_o = AM_ZP_IMM;  nregs_o = 2'd1; end
                    4'h2: begin mode_o = AM_ABS_IDX; nregs_o = 2'd3; end
                    4'h3: begin mode_o = AM_ABS_IMM; nregs_o = 2'd1; end
                    default: legal_o = 1'b0;
                endcase
            end
            CL_ALU, CL_CMP: begin
                if (lo_i == 4'h0) begin
                    mode_o  = AM_REG;
                    nregs_o = (cls_i == CL_CMP) ? 2'd2 : 2'd3;
                end else if (lo_i == 4'h1) begin
                    mode_o  = AM_IMM8;
                    nregs_o = (cls_i == CL_CMP) ? 2'd1 : 2'd2;
                end else begin
                    legal_o = 1'b0;
                end
            end
            CL_JUMP: begin
                cond_o  = lo_i[3:1];
                mode_o  = lo_i[0] ? AM_ABS_IMM : AM_ABS_IDX;
                nregs_o = lo_i[0] ? 2'd0 : 2'd2;
            end
            default: ;
        endcase
        if (zero_lo_i && (lo_i != '0))
            legal_o = 1'b0;
    end

    // Immediate bytes implied by the addressing mode.
    always_comb begin
        case (mode_o)
            AM_IMM8, AM_ZP_IMM: immb_o = 2'd1;
            AM_ABS_IMM:         immb_o = 2'd2;
            default:            immb_o = 2'd0;
        endcase
    end
endmodule

// File: rtl/opdec_length.sv
// Module: operand byte count = ceil(registers / 2) + immediate bytes.
// Assumes the sum never exceeds the LEN_W range (3 for the defaults).
module opdec_length
    import opdec_pkg::*;
(
    input  logic [REG_W-1:0] nregs_i,
    input  logic [LEN_W-1:0] immb_i,
    output logic [LEN_W-1:0] bytes_o
);
    localparam int SUM_W = (REG_W > LEN_W ? REG_W : LEN_W) + 1;
    logic [SUM_W-1:0] reg_bytes;
    logic [SUM_W-1:0] total;

    // Two register indices share one specifier byte.
    always_comb begin
        reg_bytes = (SUM_W'(nregs_i) + SUM_W'(1)) >> 1;
        total     = reg_bytes + SUM_W'(immb_i);
        bytes_o   = total[LEN_W-1:0];
    end
endmodule

// File: rtl/opcode_decoder.sv
// Module: top of the opcode decoder. Purely combinational; an illegal
// opcode forces every field to the no-operation value.
// Assumes the opcode is stable while its fields are consumed.
module opcode_decoder
    import opdec_pkg::*;
(
    input  logic [7:0] opcode_i,
    output logic [3:0] iclass_o,
    output logic [2:0] amode_o,
    output logic [3:0] alu_op_o,
    output logic [2:0] cond_o,
    output logic [1:0] operand_bytes_o,
    output logic       illegal_o
);
    iclass_e          cls;
    alu_fn_e          fn;
    amode_e           mode;
    logic             zero_lo;
    logic             legal;
    logic [2:0]       cond;
    logic [REG_W-1:0] nregs;
    logic [LEN_W-1:0] immb;
    logic [LEN_W-1:0] nbytes;

    opdec_class u_class (
        .hi_i      (opcode_i[OPC_W-1:NIB_W]),
        .cls_o     (cls),
        .fn_o      (fn),
        .zero_lo_o (zero_lo)
    );

    opdec_variant u_variant (
        .cls_i     (cls),
        .lo_i      (opcode_i[NIB_W-1:0]),
        .zero_lo_i (zero_lo),
        .mode_o    (mode),
        .cond_o    (cond),
        .legal_o   (legal),
        .nregs_o   (nregs),
        .immb_o    (immb)
    );

    opdec_length u_length (
        .nregs_i (nregs),
        .immb_i  (immb),
        .bytes_o (nbytes)
    );

    // Output masking: illegal opcodes present as no-operation.
    always_comb begin
        illegal_o       = ~legal;
        iclass_o        = legal ? cls    : CL_NOP;
        amode_o         = legal ? mode   : AM_NONE;
        alu_op_o        = legal ? fn     : FN_PASS;
        cond_o          = legal ? cond   : 3'd0;
        operand_bytes_o = legal ? nbytes : 2'd0;
    end
endmodule

// File: rtl/opcode_decoder_chk.sv
// Module: checker for opcode_decoder, relating outputs to each other and
// to the opcode. Immediate assertions, as the block has no clock.
module opcode_decoder_chk (
    input logic [7:0] opcode_i,
    input logic [3:0] iclass_o,
    input logic [2:0] amode_o,
    input logic [3:0] alu_op_o,
    input logic [2:0] cond_o,
    input logic [1:0] operand_bytes_o,
    input logic       illegal_o
);
    logic [3:0] hi;
    logic [3:0] lo;
    assign hi = opcode_i[7:4];
    assign lo = opcode_i[3:0];

    // Output relations re-checked on every opcode change.
    always_comb begin
        p_illegal_quiet_r7: assert (!illegal_o || ({iclass_o, amode_o,
            alu_op_o, cond_o, operand_bytes_o} == '0))
            else $error("illegal opcode left a field nonzero");
        p_zero_lo_only_r2: assert (!((hi == 4'h0 || hi == 4'h1 || hi == 4'hB ||
            hi == 4'hE || hi == 4'hF) && lo != 4'h0) || illegal_o)
            else $error("nonzero low nibble accepted");
        p_cond_only_jump_r6: assert (cond_o == 3'd0 || iclass_o == 4'd7)
            else $error("condition on non-jump");
        p_jump_always_legal_r6: assert (hi != 4'hD || (!illegal_o && cond_o == lo[3:1]))
            else $error("jump decode wrong");
        p_alu_class_r5: assert (alu_op_o == 4'd0 || iclass_o == 4'd4 ||
            iclass_o == 4'd5 || iclass_o == 4'd6)
            else $error("ALU code outside ALU classes");
        p_no_operands_r8: assert (!(iclass_o == 4'd0 || iclass_o == 4'd8 ||
            iclass_o == 4'd9) || operand_bytes_o == 2'd0)
            else $error("operands on nop/ret/halt");
        p_abs_imm_len_r8: assert (amode_o != 3'd6 || operand_bytes_o >= 2'd2)
            else $error("absolute immediate too short");
        p_store_range_r4: assert (hi != 4'h3 || (illegal_o == (lo > 4'h3)))
            else $error("store legality wrong");
        p_load_range_r3: assert (hi != 4'h2 || (illegal_o == (lo > 4'h4)))
            else $error("load legality wrong");
    end
endmodule

bind opcode_decoder opcode_decoder_chk u_chk (
    .opcode_i        (opcode_i),
    .iclass_o        (iclass_o),
    .amode_o         (amode_o),
    .alu_op_o        (alu_op_o),
    .cond_o          (cond_o),
    .operand_bytes_o (operand_bytes_o),
    .illegal_o       (illegal_o)
);

// File: tb/opcode_decoder_bench.sv
// Bench: directed vector table, full 256-opcode sweep against a model
// written from the requirements, then a legal-opcode count.
module opcode_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 18;

    // Vector: {opcode, class4, mode3, alu4, cond3, bytes2, illegal1}
    localparam logic [24:0] VEC [NVEC] = '{
        {8'h00, 4'd0, 3'd0, 4'd0, 3'd0, 2'd0, 1'b0},  // R1 nop
        {8'h05, 4'd0, 3'd0, 4'd0, 3'd0, 2'd0, 1'b1},  // R2
        {8'h10, 4'd1, 3'd1, 4'd0, 3'd0, 2'd1, 1'b0},  // R1 mov
        {8'h20, 4'd2, 3'd2, 4'd0, 3'd0, 2'd2, 1'b0},  // R3
        {8'h23, 4'd2, 3'd5, 4'd0, 3'd0, 2'd2, 1'b0},  // R3
        {8'h24, 4'd2, 3'd6, 4'd0, 3'd0, 2'd3, 1'b0},  // R3 R8 max
        {8'h25, 4'd0, 3'd0, 4'd0, 3'd0, 2'd0, 1'b1},  // R3 edge
        {8'h30, 4'd3, 3'd3, 4'd0, 3'd0, 2'd1, 1'b0},  // R4
        {8'h33, 4'd3, 3'd6, 4'd0, 3'd0, 2'd3, 1'b0},  // R4
        {8'h34, 4'd0, 3'd0, 4'd0, 3'd0, 2'd0, 1'b1},  // R4 edge
        {8'h40, 4'd4, 3'd1, 4'd1, 3'd0, 2'd2, 1'b0},  // R5
        {8'hA1, 4'd4, 3'd2, 4'd7, 3'd0, 2'd2, 1'b0},  // R5
        {8'h72, 4'd0, 3'd0, 4'd0, 3'd0, 2'd0, 1'b1},  // R5 R7
        {8'hB0, 4'd5, 3'd1, 4'd8, 3'd0, 2'd1, 1'b0},  // R1 shr
        {8'hC1, 4'd6, 3'd2, 4'd3, 3'd0, 2'd2, 1'b0},  // R5 cmp
        {8'hD0, 4'd7, 3'd5, 4'd0, 3'd0, 2'd1, 1'b0},  // R6
        {8'hDF, 4'd7, 3'd6, 4'd0, 3'd7, 2'd2, 1'b0},  // R6
        {8'hE1, 4'd0, 3'd0, 4'd0, 3'd0, 2'd0, 1'b1}   // R2
    };

    logic       clk;
    logic [7:0] opcode_i;
    logic [3:0] iclass_o;
    logic [2:0] amode_o;
    logic [3:0] alu_op_o;
    logic [2:0] cond_o;
    logic [1:0] operand_bytes_o;
    logic       illegal_o;
    int         n_checks;
    int         n_fail;
    int         cycles;
    bit         done;

    opcode_decoder u_opcode_decoder (
        .opcode_i        (opcode_i),
        .iclass_o        (iclass_o),
        .amode_o         (amode_o),
        .alu_op_o        (alu_op_o),
        .cond_o          (cond_o),
        .operand_bytes_o (operand_bytes_o),
        .illegal_o       (illegal_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Independent model: 17-bit expected field set for one opcode.
    function automatic logic [16:0] model(input logic [7:0] op);
        logic [3:0] h, l, c, f;
        logic [2:0] m, cd;
        int rg, im;
        bit ok;
        h = op[7:4]; l = op[3:0];
        c = 0; f = 0; m = 0; cd = 0; rg = 0; im = 0; ok = 1;
        if (h == 4'h0 || h == 4'hE || h == 4'hF) begin
            ok = (l == 0); c = (h == 0) ? 4'd0 : (h == 4'hE ? 4'd8 : 4'd9);
        end else if (h == 4'h1 || h == 4'hB) begin
            ok = (l == 0); m = 1; rg = 2;
            c = (h == 1) ? 4'd1 : 4'd5; f = (h == 1) ? 4'd0 : 4'd8;
        end else if (h == 4'h2) begin
            c = 2; ok = (l <= 4);
            m = (l == 0) ? 3'd2 : (l == 1) ? 3'd3 : (l == 2) ? 3'd4 : (l == 3) ? 3'd5 : 3'd6;
            rg = (l == 1) ? 2 : (l == 3) ? 3 : 1;
        end else if (h == 4'h3) begin
            c = 3; ok = (l <= 3); m = 3'(l + 3);
            rg = (l == 0) ? 2 : (l == 2) ? 3 : 1;
        end else if (h == 4'hD) begin
            c = 7; cd = l[3:1]; m = l[0] ? 3'd6 : 3'd5; rg = l[0] ? 0 : 2;
        end else begin
            ok = (l <= 1); m = (l == 0) ? 3'd1 : 3'd2;
            if (h == 4'hC) begin c = 6; f = 3; rg = (l == 0) ? 2 : 1; end
            else begin c = 4; f = 4'(h - 4'h3); rg = (l == 0) ? 3 : 2; end
        end
        if (m == 2 || m == 4) im = 1;
        if (m == 6) im = 2;
        if (!ok) return 17'h00001;
        return {c, m, f, cd, 2'((rg + 1) / 2 + im), 1'b0};
    endfunction

    // Apply one opcode, settle mid-cycle, compare all fields.
    task automatic check(input logic [7:0] op, input logic [16:0] exp, input string tag);
        logic [16:0] act;
        @(negedge clk);
        opcode_i = op;
        @(posedge clk);
        act = {iclass_o, amode_o, alu_op_o, cond_o, operand_bytes_o, illegal_o};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%02h actual=%05h expected=%05h", tag, op, act, exp);
        end
    endtask

    // Watchdog: an overrun counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Stimulus: table walk, full sweep, legal count.
    initial begin
        int legal_cnt;
        n_checks = 0; n_fail = 0; cycles = 0; done = 0;
        opcode_i = 8'h00;
        for (int i = 0; i < NVEC; i++)
            check(VEC[i][24:17], VEC[i][16:0], "table R1-set");
        for (int op = 0; op < 256; op++)
            check(8'(op), model(8'(op)), "sweep R1 R2 R3 R4 R5 R6 R7 R8");
        legal_cnt = 0;
        for (int op = 0; op < 256; op++) begin
            @(negedge clk);
            opcode_i = 8'(op);
            @(posedge clk);
            if (!illegal_o) legal_cnt++;
        end
        n_checks++;
        if (legal_cnt != 46) begin
            n_fail++;
            $display("FAIL R9 legal count actual=%0d expected=46", legal_cnt);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule